// File: doc/BRIEF.md
# Channel Fault and Link Health Monitor

This block observes the digital data stream of a single pressure-measurement channel together with that channel's status inputs. It turns separate failure mechanisms into one fault code and one fault-source class, so that a stalled or corrupted link, an overloaded converter or a failed excitation supply is reported as a fault and does not reach later stages looking like slow signal drift. Each channel of a multi-channel front end gets its own instance, which keeps the diagnosis local to that channel.

Samples arrive with a valid strobe and a link integrity flag. The monitor detects a run of samples held at either end of the code range, a sample whose integrity check failed, and a gap in good samples that is longer than a configured number of clock cycles. It also watches an excitation-OK line and the digital result of an external open/short detector. Live fault bits follow the present conditions. A sticky log collects every fault seen until software writes a clear. The monitor also stores the time stamp and the pass/fail result of the most recent self-test.

Top module: `chmon_fault_monitor`

## Requirements
- R1: After reset, every live and logged fault bit is 0, both codes and both sources read 0 (none), and `st_seen` is 0.
- R2: A sample is accepted when `smp_valid` and `smp_crc_ok` are both 1. After SAT_RUN (default 16) consecutive accepted samples whose code is all zeros or all ones, live bit 1 is set, with code 2 and source 3 (converter). An accepted sample with any other code clears that bit. A sample whose CRC failed neither adds to the run nor breaks it.
- R3: A valid sample with `smp_crc_ok` = 0 sets live bit 3, with code 4 and source 4 (isolation link). The bit stays set until the next valid sample that passes the check.
- R4: When `stall_limit` is N, not 0, and N clock edges pass with no accepted sample, live bit 4 is set, with code 5 and source 4. An accepted sample clears it. When `stall_limit` is 0 the stall check is off.
- R5: `exc_ok` = 0 sets live bit 2, with code 3 and source 2 (front end), one clock edge after it is sampled.
- R6: `openshort_det` = 1 sets live bit 0, with code 1 and source 1 (input), one clock edge after it is sampled.
- R7: When several live bits are set, the code follows the order stall > CRC > excitation > saturation > open/short. Code 0 and source 0 mean that no fault is present.
- R8: `log_flags` takes each live bit one edge after that bit is set, and keeps it after the bit is cleared. `log_code` and `log_src` apply the R7 order to the logged bits.
- R9: A `clear_req` pulse loads the log with the live bits of that same cycle, so a fault that is still present stays logged after the clear.
- R10: On `selftest_done` the monitor stores `time_tick` in `st_stamp` and `selftest_pass` in `st_pass`, and sets `st_seen`. When `selftest_done` is low these fields hold their values.
- R11: A valid sample that fails its CRC does not restart the stall timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_code | input | CODE_W | Converter output code |
| smp_crc_ok | input | 1 | Link integrity check of this sample passed |
| exc_ok | input | 1 | Excitation monitor reports a good supply |
| openshort_det | input | 1 | Open/short detector flag |
| stall_limit | input | TMR_W | Largest allowed gap between good samples, in clock cycles; 0 disables the check |
| clear_req | input | 1 | One-cycle write that clears the sticky log |
| selftest_done | input | 1 | Self-test finished this cycle |
| selftest_pass | input | 1 | Result of that self-test |
| time_tick | input | TS_W | Local time stamp |
| live_flags | output | 5 | Present faults: bit 0 open/short, bit 1 saturation, bit 2 excitation, bit 3 CRC, bit 4 stall |
| live_code | output | 3 | Highest-priority present fault code |
| live_src | output | 3 | Source class of live_code |
| log_flags | output | 5 | Sticky fault bits, same layout as live_flags |
| log_code | output | 3 | Highest-priority logged fault code |
| log_src | output | 3 | Source class of log_code |
| st_seen | output | 1 | A self-test has been recorded |
| st_pass | output | 1 | Result of the last self-test |
| st_stamp | output | TS_W | Time stamp of the last self-test |

## Verification
Two functions can act in the same cycle: the software clear of the sticky log and the capture of a fault that is still live. The bench holds the excitation fault active and pulses `clear_req` while it is present. It then checks that the excitation bit is still in the log after the clear. Once the fault is removed, a second clear must leave the log empty. A second overlap, a CRC failure that arrives while the stall timer is running, is judged by checking that the stall still fires at exactly the configured edge and that the stall code wins over the CRC code.

// File: rtl/chmon_pkg.sv
package chmon_pkg;

  localparam int NFLT    = 5;
  localparam int B_OPEN  = 0;
  localparam int B_SAT   = 1;
  localparam int B_EXC   = 2;
  localparam int B_CRC   = 3;
  localparam int B_STALL = 4;

  typedef enum logic [2:0] {
    FC_NONE  = 3'd0,
    FC_OPEN  = 3'd1,
    FC_SAT   = 3'd2,
    FC_EXC   = 3'd3,
    FC_CRC   = 3'd4,
    FC_STALL = 3'd5
  } fcode_t;

  typedef enum logic [2:0] {
    SRC_NONE  = 3'd0,
    SRC_INPUT = 3'd1,
    SRC_AFE   = 3'd2,
    SRC_ADC   = 3'd3,
    SRC_LINK  = 3'd4
  } fsrc_t;

  // Priority: stall > crc > excitation > saturation > open/short
  function automatic fcode_t pick_code(input logic [NFLT-1:0] f);
    if (f[B_STALL])     return FC_STALL;
    else if (f[B_CRC])  return FC_CRC;
    else if (f[B_EXC])  return FC_EXC;
    else if (f[B_SAT])  return FC_SAT;
    else if (f[B_OPEN]) return FC_OPEN;
    else                return FC_NONE;
  endfunction

  function automatic fsrc_t src_of(input fcode_t c);
    case (c)
      FC_OPEN:  return SRC_INPUT;
      FC_SAT:   return SRC_ADC;
      FC_EXC:   return SRC_AFE;
      FC_CRC:   return SRC_LINK;
      FC_STALL: return SRC_LINK;
      default:  return SRC_NONE;
    endcase
  endfunction

endpackage

// File: rtl/chmon_sat_det.sv
module chmon_sat_det #(
  parameter int CODE_W  = 16,
  parameter int SAT_RUN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [CODE_W-1:0] code,
  output logic              rail_now,
  output logic              sat_live
);
  localparam int CW = $clog2(SAT_RUN + 1);
  localparam logic [CW-1:0] RUN_C = CW'(SAT_RUN);

  function automatic logic at_rail(input logic [CODE_W-1:0] c);
    return (c == '0) || (&c);
  endfunction

  logic [CW-1:0] run_cnt;

  assign rail_now = at_rail(code);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt <= '0;
    end else if (accept) begin
      if (!rail_now)            run_cnt <= '0;
      else if (run_cnt != RUN_C) run_cnt <= run_cnt + 1'b1;
    end
  end

  assign sat_live = (run_cnt == RUN_C);
endmodule

// File: rtl/chmon_link_watch.sv
module chmon_link_watch #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic             smp_crc_ok,
  input  logic [TMR_W-1:0] stall_limit,
  output logic             crc_live,
  output logic             stall_live
);
  logic [TMR_W-1:0] gap_cnt;
  logic             crc_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_cnt <= '0;
      crc_bad <= 1'b0;
    end else begin
      if (smp_valid && smp_crc_ok) gap_cnt <= '0;
      else if (gap_cnt != '1)      gap_cnt <= gap_cnt + 1'b1;
      if (smp_valid) crc_bad <= !smp_crc_ok;
    end
  end

  assign crc_live   = crc_bad;
  assign stall_live = (stall_limit != '0) && (gap_cnt >= stall_limit);
endmodule

// File: rtl/chmon_fault_log.sv
module chmon_fault_log #(
  parameter int NF = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] live,
  input  logic          clear_req,
  output logic [NF-1:0] logged
);
  always_ff @(posedge clk) begin
    if (!rst_n) logged <= '0;
    else        logged <= (clear_req ? '0 : logged) | live;
  end
endmodule

// File: rtl/chmon_selftest_rec.sv
module chmon_selftest_rec #(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            done,
  input  logic            pass,
  input  logic [TS_W-1:0] tick,
  output logic            seen,
  output logic            pass_q,
  output logic [TS_W-1:0] stamp
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen   <= 1'b0;
      pass_q <= 1'b0;
      stamp  <= '0;
    end else if (done) begin
      seen   <= 1'b1;
      pass_q <= pass;
      stamp  <= tick;
    end
  end
endmodule

// File: rtl/chmon_fault_monitor.sv
module chmon_fault_monitor
  import chmon_pkg::*;
#(
  parameter int CODE_W  = 16,
  parameter int SAT_RUN = 16,
  parameter int TMR_W   = 16,
  parameter int TS_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [CODE_W-1:0] smp_code,
  input  logic              smp_crc_ok,
  input  logic              exc_ok,
  input  logic              openshort_det,
  input  logic [TMR_W-1:0]  stall_limit,
  input  logic              clear_req,
  input  logic              selftest_done,
  input  logic              selftest_pass,
  input  logic [TS_W-1:0]   time_tick,
  output logic [4:0]        live_flags,
  output logic [2:0]        live_code,
  output logic [2:0]        live_src,
  output logic [4:0]        log_flags,
  output logic [2:0]        log_code,
  output logic [2:0]        log_src,
  output logic              st_seen,
  output logic              st_pass,
  output logic [TS_W-1:0]   st_stamp
);
  // Named internal events, visible to the checker
  logic   accept;
  logic   rail_now;
  logic   sat_live;
  logic   crc_live;
  logic   stall_live;
  logic   exc_bad_q;
  logic   open_q;
  fcode_t live_c;
  fcode_t log_c;

  assign accept = smp_valid && smp_crc_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exc_bad_q <= 1'b0;
      open_q    <= 1'b0;
    end else begin
      exc_bad_q <= !exc_ok;
      open_q    <= openshort_det;
    end
  end

  chmon_sat_det #(.CODE_W(CODE_W), .SAT_RUN(SAT_RUN)) u_sat (
    .clk(clk), .rst_n(rst_n), .accept(accept), .code(smp_code),
    .rail_now(rail_now), .sat_live(sat_live)
  );

  chmon_link_watch #(.TMR_W(TMR_W)) u_link (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_crc_ok(smp_crc_ok),
    .stall_limit(stall_limit), .crc_live(crc_live), .stall_live(stall_live)
  );

  always_comb begin
    live_flags          = '0;
    live_flags[B_OPEN]  = open_q;
    live_flags[B_SAT]   = sat_live;
    live_flags[B_EXC]   = exc_bad_q;
    live_flags[B_CRC]   = crc_live;
    live_flags[B_STALL] = stall_live;
  end

  chmon_fault_log #(.NF(NFLT)) u_log (
    .clk(clk), .rst_n(rst_n), .live(live_flags), .clear_req(clear_req),
    .logged(log_flags)
  );

  chmon_selftest_rec #(.TS_W(TS_W)) u_st (
    .clk(clk), .rst_n(rst_n), .done(selftest_done), .pass(selftest_pass),
    .tick(time_tick), .seen(st_seen), .pass_q(st_pass), .stamp(st_stamp)
  );

  assign live_c    = pick_code(live_flags);
  assign log_c     = pick_code(log_flags);
  assign live_code = live_c;
  assign live_src  = src_of(live_c);
  assign log_code  = log_c;
  assign log_src   = src_of(log_c);
endmodule

// File: rtl/chmon_fault_monitor_chk.sv
module chmon_fault_monitor_chk #(
  parameter int TS_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            smp_valid,
  input logic            smp_crc_ok,
  input logic            rail_now,
  input logic            exc_ok,
  input logic            clear_req,
  input logic            selftest_done,
  input logic            selftest_pass,
  input logic [TS_W-1:0] time_tick,
  input logic [4:0]      live_flags,
  input logic [2:0]      live_code,
  input logic [2:0]      live_src,
  input logic [4:0]      log_flags,
  input logic            st_seen,
  input logic            st_pass,
  input logic [TS_W-1:0] st_stamp
);
  // R2: saturation only appears right after an accepted rail sample
  a_r2_sat_after_rail: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(live_flags[1]) |-> $past(smp_valid && smp_crc_ok && rail_now));

  // R4: stall and crc faults are classed as link faults when they win
  a_r4_link_src: assert property (@(posedge clk) disable iff (!rst_n)
    (live_flags[4] || live_flags[3]) |-> (live_src == 3'd4));

  // R5: excitation not-OK shows one edge later
  a_r5_exc_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_ok |=> live_flags[2]);

  // R7: no code without a flag, and a flag always gives a code
  a_r7_code_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (live_flags == 5'd0) == (live_code == 3'd0));

  // R8: every live bit reaches the log one edge later
  a_r8_live_logged: assert property (@(posedge clk) disable iff (!rst_n)
    (live_flags != 5'd0) |=> ((log_flags & $past(live_flags)) == $past(live_flags)));

  // R8: logged bits survive while no clear is written
  a_r8_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_req |=> ((log_flags & $past(log_flags)) == $past(log_flags)));

  // R9: a clear leaves exactly the faults live in that cycle
  a_r9_clear_keeps_live: assert property (@(posedge clk) disable iff (!rst_n)
    clear_req |=> (log_flags == $past(live_flags)));

  // R10: self-test record captures stamp and result
  a_r10_st_capture: assert property (@(posedge clk) disable iff (!rst_n)
    selftest_done |=> (st_seen && st_stamp == $past(time_tick) && st_pass == $past(selftest_pass)));

  a_r10_st_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !selftest_done |=> ($stable(st_stamp) && $stable(st_pass)));
endmodule

bind chmon_fault_monitor chmon_fault_monitor_chk #(.TS_W(TS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_crc_ok(smp_crc_ok),
  .rail_now(rail_now), .exc_ok(exc_ok), .clear_req(clear_req),
  .selftest_done(selftest_done), .selftest_pass(selftest_pass),
  .time_tick(time_tick), .live_flags(live_flags), .live_code(live_code),
  .live_src(live_src), .log_flags(log_flags), .st_seen(st_seen),
  .st_pass(st_pass), .st_stamp(st_stamp)
);

// File: tb/chmon_fault_monitor_test.sv
module chmon_fault_monitor_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        smp_valid;
  logic [15:0] smp_code;
  logic        smp_crc_ok;
  logic        exc_ok;
  logic        openshort_det;
  logic [15:0] stall_limit;
  logic        clear_req;
  logic        selftest_done;
  logic        selftest_pass;
  logic [31:0] time_tick;
  logic [4:0]  live_flags, log_flags;
  logic [2:0]  live_code, live_src, log_code, log_src;
  logic        st_seen, st_pass;
  logic [31:0] st_stamp;

  int errors = 0;
  int checks = 0;

  always #(CLK_P/2) clk = ~clk;

  chmon_fault_monitor uut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_code(smp_code),
    .smp_crc_ok(smp_crc_ok), .exc_ok(exc_ok), .openshort_det(openshort_det),
    .stall_limit(stall_limit), .clear_req(clear_req),
    .selftest_done(selftest_done), .selftest_pass(selftest_pass),
    .time_tick(time_tick), .live_flags(live_flags), .live_code(live_code),
    .live_src(live_src), .log_flags(log_flags), .log_code(log_code),
    .log_src(log_src), .st_seen(st_seen), .st_pass(st_pass), .st_stamp(st_stamp)
  );

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic send(input logic [15:0] c, input logic ok);
    smp_valid = 1'b1; smp_code = c; smp_crc_ok = ok;
    step();
    smp_valid = 1'b0;
  endtask

  task automatic do_clear();
    clear_req = 1'b1;
    step();
    clear_req = 1'b0;
  endtask

  task automatic t_reset();
    check_eq("R1 live_flags", live_flags, 0);
    check_eq("R1 log_flags", log_flags, 0);
    check_eq("R1 live_code", live_code, 0);
    check_eq("R1 log_src", log_src, 0);
    check_eq("R1 st_seen", st_seen, 0);
  endtask

  task automatic t_saturation();
    for (int i = 0; i < 15; i++) send(16'hFFFF, 1'b1);
    check_eq("R2 no sat after 15", live_flags[1], 0);
    send(16'hFFFF, 1'b1);
    check_eq("R2 sat after 16", live_flags[1], 1);
    check_eq("R2 sat code", live_code, 2);
    check_eq("R2 sat src", live_src, 3);
    check_eq("R8 log lags one edge", log_flags[1], 0);
    step();
    check_eq("R8 log set", log_flags[1], 1);
    send(16'h1234, 1'b1);
    check_eq("R2 sat cleared", live_flags[1], 0);
    check_eq("R8 log kept", log_flags[1], 1);
    do_clear();
    check_eq("R9 clear empties log", log_flags, 0);
    // zero-scale run with one failed-CRC sample inside
    for (int i = 0; i < 8; i++) send(16'h0000, 1'b1);
    send(16'h0000, 1'b0);
    check_eq("R3 crc code", live_code, 4);
    check_eq("R3 crc src", live_src, 4);
    for (int i = 0; i < 7; i++) send(16'h0000, 1'b1);
    check_eq("R2 bad sample not counted", live_flags[1], 0);
    check_eq("R3 crc cleared by good", live_flags[3], 0);
    send(16'h0000, 1'b1);
    check_eq("R2 sat with bad in run", live_flags[1], 1);
    send(16'h0800, 1'b1);
    step();
    do_clear();
    check_eq("R9 log empty", log_flags, 0);
  endtask

  task automatic t_priority();
    exc_ok = 1'b0; step();
    check_eq("R5 exc code", live_code, 3);
    check_eq("R5 exc src", live_src, 2);
    openshort_det = 1'b1; step();
    check_eq("R7 exc over open", live_code, 3);
    check_eq("R6 open bit", live_flags[0], 1);
    exc_ok = 1'b1; step();
    check_eq("R6 open code", live_code, 1);
    check_eq("R6 open src", live_src, 1);
    for (int i = 0; i < 16; i++) send(16'hFFFF, 1'b1);
    check_eq("R7 sat over open", live_code, 2);
    exc_ok = 1'b0; step();
    check_eq("R7 exc over sat", live_code, 3);
    send(16'hFFFF, 1'b0);
    check_eq("R7 crc over exc", live_code, 4);
    check_eq("R7 flags all low four", live_flags, 5'b01111);
    step();
    check_eq("R8 log code", log_code, 4);
    exc_ok = 1'b1; openshort_det = 1'b0;
    send(16'h0100, 1'b1);
    step();
    check_eq("R7 none", live_code, 0);
    do_clear();
    check_eq("R9 log empty after prio", log_flags, 0);
  endtask

  task automatic t_stall();
    stall_limit = 16'd5;
    send(16'h0010, 1'b1);
    repeat (4) step();
    check_eq("R4 no stall at 4", live_flags[4], 0);
    step();
    check_eq("R4 stall at 5", live_flags[4], 1);
    check_eq("R4 stall code", live_code, 5);
    check_eq("R4 stall src", live_src, 4);
    send(16'h0010, 1'b1);
    check_eq("R4 stall cleared", live_flags[4], 0);
    step();
    send(16'h0010, 1'b0);
    repeat (2) step();
    check_eq("R11 no stall at 4", live_flags[4], 0);
    step();
    check_eq("R11 bad crc no restart", live_flags[4], 1);
    check_eq("R7 stall over crc", live_code, 5);
    check_eq("R7 crc also live", live_flags[3], 1);
    send(16'h0010, 1'b1);
    stall_limit = 16'd0;
    repeat (20) step();
    check_eq("R4 disabled", live_flags[4], 0);
    do_clear();
    check_eq("R9 log empty after stall", log_flags, 0);
  endtask

  task automatic t_clear_collide();
    exc_ok = 1'b0; step();
    do_clear();
    check_eq("R9 live fault survives clear", log_flags[2], 1);
    exc_ok = 1'b1; step();
    do_clear();
    check_eq("R9 log empty once gone", log_flags, 0);
  endtask

  task automatic t_selftest();
    time_tick = 32'h0000ABCD; selftest_pass = 1'b1; selftest_done = 1'b1;
    step();
    selftest_done = 1'b0;
    check_eq("R10 seen", st_seen, 1);
    check_eq("R10 pass", st_pass, 1);
    check_eq("R10 stamp", st_stamp, 32'h0000ABCD);
    time_tick = 32'd500; selftest_pass = 1'b0;
    step();
    check_eq("R10 stamp holds", st_stamp, 32'h0000ABCD);
    check_eq("R10 pass holds", st_pass, 1);
    time_tick = 32'd77; selftest_done = 1'b1;
    step();
    selftest_done = 1'b0;
    check_eq("R10 stamp new", st_stamp, 77);
    check_eq("R10 fail result", st_pass, 0);
  endtask

  initial begin
    rst_n = 1'b0; smp_valid = 1'b0; smp_code = '0; smp_crc_ok = 1'b1;
    exc_ok = 1'b1; openshort_det = 1'b0; stall_limit = '0; clear_req = 1'b0;
    selftest_done = 1'b0; selftest_pass = 1'b0; time_tick = '0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_saturation();
    t_priority();
    t_stall();
    t_clear_collide();
    t_selftest();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule